// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block is the control unit of a one-instruction-per-clock 32-bit load/store processor. It is purely combinational. It takes the 6-bit primary opcode, the 6-bit function field of register-format instructions, the ALU zero flag and the reset and interrupt request lines. From these it produces every steering and enable signal the datapath needs for the current cycle: the next-PC source, the immediate extension mode, the destination-register and write-back selectors, the 5-bit ALU function, the two ALU operand sources and the register-file and data-memory write enables.

One decision table covers the whole instruction set. It handles three-register ALU operations, constant and variable shifts, immediate ALU operations, word loads and stores, equality branches, direct and register jumps with optional linking, signed and unsigned set-less-than, and load-upper-immediate. The same table also handles boot, interrupt entry and the trap on an undefined encoding. Load-upper-immediate needs no extra datapath: the decoder points the shifter's amount input at a constant 16 and shifts the extended immediate left.

Any output field that a requirement does not name for a given case is driven to 0.

Top module: `ctl_decoder_sc`

## Requirements
- R1: Opcode 000000 with function 100000/100001 (add), 100010/100011 (subtract), 100100 (and), 100101 (or), 100110 (xor) or 100111 (nor) drives the ALU function {sub, bool[1:0], shift, math} as 00001, 10001, 00000, 00100, 01000 and 01100. It selects destination rd (dst_sel_o=0), write-back ALU (wb_src_o=1), operand A from rs (opa_src_o=0), operand B from rt (opb_imm_o=0) and sets rf_we_o.
- R2: Under opcode 000000, the shifts left-logical, right-logical and right-arithmetic use ALU functions 00010, 00110 and 01110. Function codes 000000/000010/000011 take the amount from the shamt field (opa_src_o=1). Codes 000100/000110/000111 take it from rs (opa_src_o=0). The value shifted is rt, written to rd through the ALU path.
- R3: Opcodes 001000/001001 (add), 001100 (and), 001101 (or) and 001110 (xor) write the ALU result to rt (dst_sel_o=1) with operand B the extended immediate (opb_imm_o=1). Sign extension (ext_sign_o=1) applies to the add forms only; the logic forms zero-extend. The function field is ignored.
- R4: Opcode 001111 writes rt with the immediate shifted left by 16: ALU function 00010, opa_src_o=2 (constant 16), opb_imm_o=1, zero extension.
- R5: Opcode 100011 (load word) adds rs and the sign-extended immediate and writes memory read data (wb_src_o=2) to rt, with no memory write.
- R6: Opcode 101011 (store word) adds rs and the sign-extended immediate and sets dmem_we_o while rf_we_o stays 0.
- R7: Opcodes 000100 (equal) and 000101 (not equal) drive ALU function 10001 with operand B rt and sign extension, and write nothing. next_pc_o is 1 (branch target) when zero_i is 1 for 000100 or 0 for 000101, and 0 (PC+4) otherwise.
- R8: Opcodes 000010 and 000011 select next_pc_o=2 (jump target). 000011 additionally writes PC+4 (wb_src_o=0) into register 31 (dst_sel_o=2).
- R9: Opcode 000000 with function 001000 selects next_pc_o=3 (register rs). Function 001001 additionally writes PC+4 into rd.
- R10: Set-less-than uses ALU function 10011 (signed) and 10111 (unsigned). It applies to functions 101010/101011 under opcode 000000 (writing rd from rs, rt) and to opcodes 001010/001011 (writing rt, sign-extended immediate).
- R11: Any opcode or opcode-000000 function code not listed above traps: next_pc_o=4, PC+4 is written to register 27 (dst_sel_o=3, wb_src_o=0, rf_we_o=1), and there is no memory write.
- R12: With rst_i low and irq_i high, any instruction is overridden: next_pc_o=5, PC+4 is written to register 27, and there is no memory write.
- R13: rst_i high outranks everything: next_pc_o=6 and no register or memory write, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Primary opcode field |
| fn_i | input | 6 | Function field for opcode 000000 |
| zero_i | input | 1 | ALU zero flag of the current instruction |
| rst_i | input | 1 | Reset request, highest priority |
| irq_i | input | 1 | Interrupt request |
| next_pc_o | output | 3 | Next PC source: 0 PC+4, 1 branch, 2 jump, 3 rs, 4 trap vector, 5 interrupt vector, 6 boot vector |
| ext_sign_o | output | 1 | 1 sign-extends the immediate, 0 zero-extends it |
| dst_sel_o | output | 2 | Destination: 0 rd, 1 rt, 2 register 31, 3 register 27 |
| wb_src_o | output | 2 | Write-back data: 0 PC+4, 1 ALU, 2 memory |
| alu_fn_o | output | 5 | ALU function {sub, bool[1:0], shift, math} |
| dmem_we_o | output | 1 | Data memory write enable |
| rf_we_o | output | 1 | Register file write enable |
| opa_src_o | output | 2 | ALU A operand: 0 rs, 1 shamt, 2 constant 16 |
| opb_imm_o | output | 1 | ALU B operand: 0 rt, 1 extended immediate |

## Verification
The checks are immediate assertions evaluated whenever an input or output changes. They assume every input is a known 0/1 value and that all inputs of one instruction are presented together, so the decoder never has to be judged on a half-applied mix of fields. The bench holds that contract: it assigns opcode, function, flag, reset and interrupt in a single step of one process and reads the outputs half a clock later. It then sweeps all 64 opcodes under reset, under interrupt and with both lines low.

// File: rtl/ctl_decoder_sc.sv
`timescale 1ns/1ps
module ctl_decoder_sc (
  input  logic [5:0] op_i,
  input  logic [5:0] fn_i,
  input  logic       zero_i,
  input  logic       rst_i,
  input  logic       irq_i,
  output logic [2:0] next_pc_o,
  output logic       ext_sign_o,
  output logic [1:0] dst_sel_o,
  output logic [1:0] wb_src_o,
  output logic [4:0] alu_fn_o,
  output logic       dmem_we_o,
  output logic       rf_we_o,
  output logic [1:0] opa_src_o,
  output logic       opb_imm_o
);

  localparam logic [4:0] FN_ADD  = 5'b00001;
  localparam logic [4:0] FN_SUB  = 5'b10001;
  localparam logic [4:0] FN_AND  = 5'b00000;
  localparam logic [4:0] FN_OR   = 5'b00100;
  localparam logic [4:0] FN_XOR  = 5'b01000;
  localparam logic [4:0] FN_NOR  = 5'b01100;
  localparam logic [4:0] FN_SLL  = 5'b00010;
  localparam logic [4:0] FN_SRL  = 5'b00110;
  localparam logic [4:0] FN_SRA  = 5'b01110;
  localparam logic [4:0] FN_SLT  = 5'b10011;
  localparam logic [4:0] FN_SLTU = 5'b10111;

  localparam logic [2:0] NPC_SEQ  = 3'd0;
  localparam logic [2:0] NPC_BR   = 3'd1;
  localparam logic [2:0] NPC_JMP  = 3'd2;
  localparam logic [2:0] NPC_REG  = 3'd3;
  localparam logic [2:0] NPC_TRAP = 3'd4;
  localparam logic [2:0] NPC_IRQ  = 3'd5;
  localparam logic [2:0] NPC_BOOT = 3'd6;

  localparam logic [1:0] DST_RD   = 2'd0;
  localparam logic [1:0] DST_RT   = 2'd1;
  localparam logic [1:0] DST_LINK = 2'd2;
  localparam logic [1:0] DST_EXC  = 2'd3;

  localparam logic [1:0] WB_PC4 = 2'd0;
  localparam logic [1:0] WB_ALU = 2'd1;
  localparam logic [1:0] WB_MEM = 2'd2;

  localparam logic [1:0] OPA_RS  = 2'd0;
  localparam logic [1:0] OPA_SH  = 2'd1;
  localparam logic [1:0] OPA_K16 = 2'd2;

  typedef enum logic [2:0] {RK_ALU, RK_SHC, RK_SHV, RK_JR, RK_JALR, RK_BAD} rkind_t;

  rkind_t     r_kind;
  logic [4:0] r_fn;
  logic [4:0] i_fn;
  logic       i_sx;

  always_comb begin
    r_kind = RK_ALU;
    r_fn   = FN_ADD;
    case (fn_i)
      6'b100000, 6'b100001: r_fn = FN_ADD;
      6'b100010, 6'b100011: r_fn = FN_SUB;
      6'b100100:            r_fn = FN_AND;
      6'b100101:            r_fn = FN_OR;
      6'b100110:            r_fn = FN_XOR;
      6'b100111:            r_fn = FN_NOR;
      6'b101010:            r_fn = FN_SLT;
      6'b101011:            r_fn = FN_SLTU;
      6'b000000: begin r_kind = RK_SHC; r_fn = FN_SLL; end
      6'b000010: begin r_kind = RK_SHC; r_fn = FN_SRL; end
      6'b000011: begin r_kind = RK_SHC; r_fn = FN_SRA; end
      6'b000100: begin r_kind = RK_SHV; r_fn = FN_SLL; end
      6'b000110: begin r_kind = RK_SHV; r_fn = FN_SRL; end
      6'b000111: begin r_kind = RK_SHV; r_fn = FN_SRA; end
      6'b001000: r_kind = RK_JR;
      6'b001001: r_kind = RK_JALR;
      default:   r_kind = RK_BAD;
    endcase
  end

  always_comb begin
    case (op_i[2:0])
      3'b000, 3'b001: begin i_fn = FN_ADD;  i_sx = 1'b1; end
      3'b010:         begin i_fn = FN_SLT;  i_sx = 1'b1; end
      3'b011:         begin i_fn = FN_SLTU; i_sx = 1'b1; end
      3'b100:         begin i_fn = FN_AND;  i_sx = 1'b0; end
      3'b101:         begin i_fn = FN_OR;   i_sx = 1'b0; end
      3'b110:         begin i_fn = FN_XOR;  i_sx = 1'b0; end
      default:        begin i_fn = FN_SLL;  i_sx = 1'b0; end
    endcase
  end

  always_comb begin
    next_pc_o  = NPC_SEQ;
    ext_sign_o = 1'b0;
    dst_sel_o  = DST_RD;
    wb_src_o   = WB_PC4;
    alu_fn_o   = FN_AND;
    dmem_we_o  = 1'b0;
    rf_we_o    = 1'b0;
    opa_src_o  = OPA_RS;
    opb_imm_o  = 1'b0;
    if (rst_i) begin
      next_pc_o = NPC_BOOT;
    end else if (irq_i) begin
      next_pc_o = NPC_IRQ;
      rf_we_o   = 1'b1;
      dst_sel_o = DST_EXC;
    end else begin
      casez (op_i)
        6'b000000: begin
          case (r_kind)
            RK_ALU: begin
              alu_fn_o = r_fn; wb_src_o = WB_ALU; rf_we_o = 1'b1;
            end
            RK_SHC: begin
              alu_fn_o = r_fn; wb_src_o = WB_ALU; rf_we_o = 1'b1; opa_src_o = OPA_SH;
            end
            RK_SHV: begin
              alu_fn_o = r_fn; wb_src_o = WB_ALU; rf_we_o = 1'b1;
            end
            RK_JR:   next_pc_o = NPC_REG;
            RK_JALR: begin next_pc_o = NPC_REG; rf_we_o = 1'b1; end
            default: begin
              next_pc_o = NPC_TRAP; rf_we_o = 1'b1; dst_sel_o = DST_EXC;
            end
          endcase
        end
        6'b001???: begin
          dst_sel_o = DST_RT;
          wb_src_o  = WB_ALU;
          rf_we_o   = 1'b1;
          opb_imm_o = 1'b1;
          alu_fn_o  = i_fn;
          ext_sign_o = i_sx;
          if (op_i[2:0] == 3'b111) opa_src_o = OPA_K16;
        end
        6'b100011: begin
          alu_fn_o = FN_ADD; ext_sign_o = 1'b1; opb_imm_o = 1'b1;
          dst_sel_o = DST_RT; wb_src_o = WB_MEM; rf_we_o = 1'b1;
        end
        6'b101011: begin
          alu_fn_o = FN_ADD; ext_sign_o = 1'b1; opb_imm_o = 1'b1; dmem_we_o = 1'b1;
        end
        6'b00010?: begin
          alu_fn_o   = FN_SUB;
          ext_sign_o = 1'b1;
          next_pc_o  = (zero_i ^ op_i[0]) ? NPC_BR : NPC_SEQ;
        end
        6'b00001?: begin
          next_pc_o = NPC_JMP;
          if (op_i[0]) begin
            rf_we_o = 1'b1; dst_sel_o = DST_LINK;
          end
        end
        default: begin
          next_pc_o = NPC_TRAP; rf_we_o = 1'b1; dst_sel_o = DST_EXC;
        end
      endcase
    end
  end

endmodule

module ctl_decoder_sc_props (
  input logic [5:0] op_i,
  input logic [5:0] fn_i,
  input logic       zero_i,
  input logic       rst_i,
  input logic       irq_i,
  input logic [2:0] next_pc_o,
  input logic [1:0] dst_sel_o,
  input logic [1:0] wb_src_o,
  input logic       dmem_we_o,
  input logic       rf_we_o,
  input logic       opb_imm_o
);
  always_comb begin
    if (rst_i)
      p_reset_quiet_r13: assert (next_pc_o == 3'd6 && !rf_we_o && !dmem_we_o);
    if (!rst_i && irq_i)
      p_irq_redirect_r12: assert (next_pc_o == 3'd5 && rf_we_o && dst_sel_o == 2'd3 && !dmem_we_o);
    if (dmem_we_o)
      p_store_no_regwrite_r6: assert (!rf_we_o && opb_imm_o && op_i == 6'b101011);
    if (wb_src_o == 2'd2)
      p_memdata_load_r5: assert (rf_we_o && op_i == 6'b100011 && !rst_i && !irq_i);
    if (next_pc_o == 3'd1)
      p_branch_taken_r7: assert (op_i[5:1] == 5'b00010 && (zero_i ^ op_i[0]) && !rf_we_o);
    if (dst_sel_o == 2'd2)
      p_link_dest_r8: assert (op_i == 6'b000011 && next_pc_o == 3'd2 && wb_src_o == 2'd0);
    if (!rst_i && !irq_i && op_i == 6'b000000 && fn_i == 6'b001000)
      p_reg_jump_r9: assert (next_pc_o == 3'd3 && !rf_we_o);
  end
endmodule

bind ctl_decoder_sc ctl_decoder_sc_props u_props (
  .op_i(op_i), .fn_i(fn_i), .zero_i(zero_i), .rst_i(rst_i), .irq_i(irq_i),
  .next_pc_o(next_pc_o), .dst_sel_o(dst_sel_o), .wb_src_o(wb_src_o),
  .dmem_we_o(dmem_we_o), .rf_we_o(rf_we_o), .opb_imm_o(opb_imm_o)
);

// File: tb/tb_ctl_decoder_sc.sv
`timescale 1ns/1ps
module tb_ctl_decoder_sc;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [5:0] op, fn;
  logic       z, rst, irq;
  logic [2:0] npc;
  logic       sx;
  logic [1:0] da, wd;
  logic [4:0] alu;
  logic       mw, rw;
  logic [1:0] as;
  logic       bs;

  ctl_decoder_sc dut (
    .op_i(op), .fn_i(fn), .zero_i(z), .rst_i(rst), .irq_i(irq),
    .next_pc_o(npc), .ext_sign_o(sx), .dst_sel_o(da), .wb_src_o(wd),
    .alu_fn_o(alu), .dmem_we_o(mw), .rf_we_o(rw), .opa_src_o(as), .opb_imm_o(bs)
  );

  wire [17:0] got = {npc, sx, da, wd, alu, mw, rw, as, bs};

  localparam logic [4:0] ADD = 5'b00001, SUB = 5'b10001, AND_ = 5'b00000, OR_ = 5'b00100,
                         XOR_ = 5'b01000, NOR_ = 5'b01100, SLL = 5'b00010, SRL = 5'b00110,
                         SRA = 5'b01110, SLT = 5'b10011, SLTU = 5'b10111;

  typedef struct packed {
    logic [3:0] req;
    logic rst, irq, z;
    logic [5:0] op, fn;
    logic [2:0] pc;
    logic sx;
    logic [1:0] da, wd;
    logic [4:0] alu;
    logic mw, rw;
    logic [1:0] as;
    logic bs;
  } tv_t;

  localparam int NV = 50;
  localparam tv_t TV [NV] = '{
    '{13, 1,0,0, 6'b000000, 6'b100000, 6,0,0,0,AND_,0,0,0,0},  // R13 reset state
    '{1,  0,0,0, 6'b000000, 6'b100000, 0,0,0,1,ADD, 0,1,0,0},  // R1
    '{1,  0,0,1, 6'b000000, 6'b100001, 0,0,0,1,ADD, 0,1,0,0},  // R1
    '{1,  0,0,0, 6'b000000, 6'b100010, 0,0,0,1,SUB, 0,1,0,0},  // R1
    '{1,  0,0,0, 6'b000000, 6'b100011, 0,0,0,1,SUB, 0,1,0,0},  // R1
    '{1,  0,0,0, 6'b000000, 6'b100100, 0,0,0,1,AND_,0,1,0,0},  // R1
    '{1,  0,0,0, 6'b000000, 6'b100101, 0,0,0,1,OR_, 0,1,0,0},  // R1
    '{1,  0,0,0, 6'b000000, 6'b100110, 0,0,0,1,XOR_,0,1,0,0},  // R1
    '{1,  0,0,0, 6'b000000, 6'b100111, 0,0,0,1,NOR_,0,1,0,0},  // R1
    '{2,  0,0,0, 6'b000000, 6'b000000, 0,0,0,1,SLL, 0,1,1,0},  // R2
    '{2,  0,0,0, 6'b000000, 6'b000010, 0,0,0,1,SRL, 0,1,1,0},  // R2
    '{2,  0,0,0, 6'b000000, 6'b000011, 0,0,0,1,SRA, 0,1,1,0},  // R2
    '{2,  0,0,0, 6'b000000, 6'b000100, 0,0,0,1,SLL, 0,1,0,0},  // R2
    '{2,  0,0,0, 6'b000000, 6'b000110, 0,0,0,1,SRL, 0,1,0,0},  // R2
    '{2,  0,0,0, 6'b000000, 6'b000111, 0,0,0,1,SRA, 0,1,0,0},  // R2
    '{10, 0,0,0, 6'b000000, 6'b101010, 0,0,0,1,SLT, 0,1,0,0},  // R10
    '{10, 0,0,0, 6'b000000, 6'b101011, 0,0,0,1,SLTU,0,1,0,0},  // R10
    '{9,  0,0,0, 6'b000000, 6'b001000, 3,0,0,0,AND_,0,0,0,0},  // R9
    '{9,  0,0,1, 6'b000000, 6'b001001, 3,0,0,0,AND_,0,1,0,0},  // R9
    '{3,  0,0,0, 6'b001000, 6'b111111, 0,1,1,1,ADD, 0,1,0,1},  // R3
    '{3,  0,0,0, 6'b001001, 6'b001000, 0,1,1,1,ADD, 0,1,0,1},  // R3
    '{3,  0,0,0, 6'b001100, 6'b000000, 0,0,1,1,AND_,0,1,0,1},  // R3
    '{3,  0,0,0, 6'b001101, 6'b101010, 0,0,1,1,OR_, 0,1,0,1},  // R3
    '{3,  0,0,0, 6'b001110, 6'b000011, 0,0,1,1,XOR_,0,1,0,1},  // R3
    '{10, 0,0,0, 6'b001010, 6'b000000, 0,1,1,1,SLT, 0,1,0,1},  // R10
    '{10, 0,0,0, 6'b001011, 6'b000000, 0,1,1,1,SLTU,0,1,0,1},  // R10
    '{4,  0,0,0, 6'b001111, 6'b010101, 0,0,1,1,SLL, 0,1,2,1},  // R4
    '{5,  0,0,0, 6'b100011, 6'b000000, 0,1,1,2,ADD, 0,1,0,1},  // R5
    '{6,  0,0,0, 6'b101011, 6'b100000, 0,1,0,0,ADD, 1,0,0,1},  // R6
    '{7,  0,0,1, 6'b000100, 6'b000000, 1,1,0,0,SUB, 0,0,0,0},  // R7 beq taken
    '{7,  0,0,0, 6'b000100, 6'b000000, 0,1,0,0,SUB, 0,0,0,0},  // R7 beq not taken
    '{7,  0,0,0, 6'b000101, 6'b000000, 1,1,0,0,SUB, 0,0,0,0},  // R7 bne taken
    '{7,  0,0,1, 6'b000101, 6'b000000, 0,1,0,0,SUB, 0,0,0,0},  // R7 bne not taken
    '{8,  0,0,0, 6'b000010, 6'b000000, 2,0,0,0,AND_,0,0,0,0},  // R8
    '{8,  0,0,1, 6'b000011, 6'b100000, 2,0,2,0,AND_,0,1,0,0},  // R8
    '{11, 0,0,0, 6'b111111, 6'b100000, 4,0,3,0,AND_,0,1,0,0},  // R11
    '{11, 0,0,0, 6'b000001, 6'b000000, 4,0,3,0,AND_,0,1,0,0},  // R11
    '{11, 0,0,0, 6'b100000, 6'b000000, 4,0,3,0,AND_,0,1,0,0},  // R11
    '{11, 0,0,0, 6'b000000, 6'b000001, 4,0,3,0,AND_,0,1,0,0},  // R11 bad function
    '{11, 0,0,0, 6'b000000, 6'b111111, 4,0,3,0,AND_,0,1,0,0},  // R11 bad function
    '{11, 0,0,0, 6'b000000, 6'b001010, 4,0,3,0,AND_,0,1,0,0},  // R11 bad function
    '{12, 0,1,0, 6'b101011, 6'b000000, 5,0,3,0,AND_,0,1,0,0},  // R12 over store
    '{12, 0,1,1, 6'b000100, 6'b000000, 5,0,3,0,AND_,0,1,0,0},  // R12 over taken branch
    '{12, 0,1,0, 6'b111111, 6'b000000, 5,0,3,0,AND_,0,1,0,0},  // R12 over trap
    '{12, 0,1,0, 6'b000011, 6'b000000, 5,0,3,0,AND_,0,1,0,0},  // R12 over link jump
    '{13, 1,1,0, 6'b111111, 6'b000000, 6,0,0,0,AND_,0,0,0,0},  // R13 over irq and trap
    '{13, 1,0,0, 6'b101011, 6'b000000, 6,0,0,0,AND_,0,0,0,0},  // R13 over store
    '{13, 1,0,0, 6'b000011, 6'b000000, 6,0,0,0,AND_,0,0,0,0},  // R13 over link jump
    '{13, 1,1,1, 6'b100011, 6'b000000, 6,0,0,0,AND_,0,0,0,0},  // R13 over load
    '{1,  0,0,0, 6'b000000, 6'b100111, 0,0,0,1,NOR_,0,1,0,0}   // R1 after reset released
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input int req, input logic [17:0] act, input logic [17:0] exp, input logic [17:0] mask);
    checks++;
    if ((act & mask) !== (exp & mask)) begin
      fails++;
      $display("FAIL R%0d op=%b fn=%b z=%b rst=%b irq=%b actual=%h expected=%h",
               req, op, fn, z, rst, irq, act & mask, exp & mask);
    end
  endtask

  task automatic apply(input logic r, input logic q, input logic zz, input logic [5:0] o, input logic [5:0] f);
    @(posedge clk);
    rst = r; irq = q; z = zz; op = o; fn = f;
    @(negedge clk);
  endtask

  function automatic bit legal_op(input logic [5:0] o);
    return (o == 6'b000000) || (o[5:3] == 3'b001) || (o == 6'b100011) ||
           (o == 6'b101011) || (o[5:1] == 5'b00001) || (o[5:1] == 5'b00010);
  endfunction

  localparam logic [17:0] M_PC_WR = 18'b111_0_00_00_00000_1_1_00_0;
  localparam logic [17:0] M_ALL   = 18'h3FFFF;

  initial begin
    rst = 1'b1; irq = 1'b0; z = 1'b0; op = 6'b0; fn = 6'b0;
    for (int i = 0; i < NV; i++) begin
      apply(TV[i].rst, TV[i].irq, TV[i].z, TV[i].op, TV[i].fn);
      check(int'(TV[i].req), got,
            {TV[i].pc, TV[i].sx, TV[i].da, TV[i].wd, TV[i].alu, TV[i].mw, TV[i].rw, TV[i].as, TV[i].bs},
            M_ALL);
    end
    // R13: reset sweep over every opcode, with irq and zero varied
    for (int o = 0; o < 64; o++) begin
      apply(1'b1, o[0], o[1], 6'(o), 6'(63 - o));
      check(13, got, {3'd6, 15'd0}, M_PC_WR);
    end
    // R12: interrupt sweep over every opcode
    for (int o = 0; o < 64; o++) begin
      apply(1'b0, 1'b1, o[2], 6'(o), 6'(o));
      check(12, got, {3'd5, 1'b0, 2'd3, 2'd0, 5'd0, 1'b0, 1'b1, 2'd0, 1'b0}, M_ALL);
    end
    // R11: every undefined opcode traps
    for (int o = 0; o < 64; o++) begin
      if (!legal_op(6'(o))) begin
        apply(1'b0, 1'b0, o[0], 6'(o), 6'b100000);
        check(11, got, {3'd4, 1'b0, 2'd3, 2'd0, 5'd0, 1'b0, 1'b1, 2'd0, 1'b0}, M_ALL);
      end
    end
    // R3: immediate forms ignore the function field
    for (int f = 0; f < 64; f += 7) begin
      apply(1'b0, 1'b0, 1'b0, 6'b001101, 6'(f));
      check(3, got, {3'd0, 1'b0, 2'd1, 2'd1, 5'b00100, 1'b0, 1'b1, 2'd0, 1'b1}, M_ALL);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (R1..R13 run incomplete) actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule